// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller connects a simple synchronous request port to a 4M x 4 dynamic memory whose 2048 x 2048 x 4 array is reached through one 11-bit address pin group. Each request carries a 22-bit word address, a read/write flag and a 4-bit write value. The controller splits the address into an 11-bit row (upper half) and an 11-bit column (lower half). It presents the row with the row strobe and then the column, on the same pins, with the column strobe. The column strobe comes with either the write enable or the output enable. A fixed precharge interval follows, during which every strobe is inactive, so that the sensed row can be restored before the next row strobe.

The request side uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request steady until that edge. `req_ready` depends only on the controller's state, never on `req_valid`. Completion is a plain one-cycle `rsp_valid` pulse that cannot be stalled; `rsp_rdata` carries the read value and is meaningful for reads only.

Stored charge leaks, so a timer raises a refresh request every `REF_PERIOD` cycles. A refresh strobes only the row. Its row comes from an internal counter that steps by one after each refresh and wraps at the last row. A pending refresh wins over any waiting access at the next idle point.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`, active low) are high, `rsp_valid` is low and `req_ready` is high.
- R2: For an access, `dram_addr` carries `req_addr[21:11]` from the row strobe falling edge until the column strobe falls, and carries `req_addr[10:0]` while the column strobe is low.
- R3: The column strobe is low only while the row strobe is low, and it falls exactly `T_ROW` cycles after the row strobe falls.
- R4: A write drives `dram_we_n` low, `dram_oe_n` high and the write value on `dram_dq_out` while the column strobe is low. A read drives `dram_oe_n` low and `dram_we_n` high. The two enables are never low together.
- R5: A read returns the value last written to the same 22-bit address. The value is sampled from `dram_dq_in` on the last clock edge before the column strobe rises.
- R6: `rsp_valid` is high for exactly one cycle per accepted request, on the `T_ROW+T_COL+T_DATA`-th clock edge after the accepting edge.
- R7: `req_ready` is low whenever the row strobe is low, and a request held through back-pressure is performed exactly once.
- R8: Between two low periods of the row strobe it stays high for at least `T_PRE` cycles.
- R9: Every `REF_PERIOD` cycles a refresh is requested. A refresh keeps the row strobe low for `T_REF` cycles while the column strobe stays high. Its row is 0 for the first refresh and one more (modulo 2048) for each refresh after that.
- R10: While a refresh is pending, `req_ready` is low, so the refresh starts before any waiting access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read value, valid with `rsp_valid` for reads |
| dram_addr | output | 11 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data toward the memory |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
Each response is due on the clock edge `T_ROW+T_COL+T_DATA` edges after the accepting edge. The driver stamps that exact cycle into each scoreboard entry, and the monitor compares it with the cycle in which `rsp_valid` is seen. The pin-level memory model samples all strobes on falling clock edges, half a cycle after they change. It checks the row/column split when the column strobe falls, and the column strobe falls `T_ROW` cycles after the row strobe. Refresh deadlines are recomputed from the bench's own cycle count as multiples of `REF_PERIOD`. Every row-strobe falling edge is then classified as refresh or access and compared with that expectation.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_COL,
    PH_DATA,
    PH_PRE,
    PH_REF
  } phase_e;

  typedef struct packed {
    logic        wr;
    logic [10:0] row;
    logic [10:0] col;
    logic [3:0]  data;
  } access_t;
endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int REF_PERIOD = 1560,
  parameter int PIN_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             ref_done,
  output logic             pending,
  output logic [PIN_W-1:0] ref_row
);
  localparam int TICK_W = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

  logic [TICK_W-1:0] tick_q;
  logic              expire;

  assign expire = (tick_q == TICK_W'(REF_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      pending <= 1'b0;
      ref_row <= '0;
    end else begin
      tick_q <= expire ? '0 : tick_q + 1'b1;
      if (grant)    pending <= 1'b0;
      if (expire)   pending <= 1'b1;
      if (ref_done) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_addr_sel.sv
module dram_addr_sel #(
  parameter int PIN_W = 11
) (
  input  logic             use_col,
  input  logic             use_ref,
  input  logic [PIN_W-1:0] row,
  input  logic [PIN_W-1:0] col,
  input  logic [PIN_W-1:0] ref_row,
  output logic [PIN_W-1:0] pins
);
  always_comb begin
    if (use_ref)      pins = ref_row;
    else if (use_col) pins = col;
    else              pins = row;
  end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_mux_pkg::*;
#(
  parameter int PIN_W      = 11,
  parameter int DATA_W     = 4,
  parameter int T_ROW      = 2,
  parameter int T_COL      = 2,
  parameter int T_DATA     = 1,
  parameter int T_PRE      = 2,
  parameter int T_REF      = 3,
  parameter int REF_PERIOD = 1560
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [2*PIN_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [PIN_W-1:0]     dram_addr,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [DATA_W-1:0]    dram_dq_out,
  input  logic [DATA_W-1:0]    dram_dq_in
);
  localparam int M_A   = (T_ROW > T_COL) ? T_ROW : T_COL;
  localparam int M_B   = (T_DATA > T_PRE) ? T_DATA : T_PRE;
  localparam int M_C   = (M_A > M_B) ? M_A : M_B;
  localparam int T_MAX = (M_C > T_REF) ? M_C : T_REF;
  localparam int CNT_W = $clog2(T_MAX + 1);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic               wr_q;
  logic [PIN_W-1:0]   row_q, col_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               ref_pending, ref_grant, ref_done;
  logic [PIN_W-1:0]   ref_row;
  logic               last;
  logic               in_cas;

  assign last      = (cnt == '0);
  assign ref_grant = (phase == PH_IDLE) && ref_pending;
  assign ref_done  = (phase == PH_REF) && last;

  dram_refresh_sched #(.REF_PERIOD(REF_PERIOD), .PIN_W(PIN_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (ref_grant),
    .ref_done (ref_done),
    .pending  (ref_pending),
    .ref_row  (ref_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (ref_pending) begin
            phase <= PH_REF;
            cnt   <= CNT_W'(T_REF - 1);
          end else if (req_valid) begin
            phase   <= PH_ROW;
            cnt     <= CNT_W'(T_ROW - 1);
            wr_q    <= req_write;
            row_q   <= req_addr[2*PIN_W-1:PIN_W];
            col_q   <= req_addr[PIN_W-1:0];
            wdata_q <= req_wdata;
          end
        end
        PH_ROW: begin
          if (last) begin
            phase <= PH_COL;
            cnt   <= CNT_W'(T_COL - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_COL: begin
          if (last) begin
            phase <= PH_DATA;
            cnt   <= CNT_W'(T_DATA - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_DATA: begin
          if (last) begin
            if (!wr_q) rsp_rdata <= dram_dq_in;
            rsp_valid <= 1'b1;
            phase     <= PH_PRE;
            cnt       <= CNT_W'(T_PRE - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_REF: begin
          if (last) begin
            phase <= PH_PRE;
            cnt   <= CNT_W'(T_PRE - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_PRE: begin
          if (last) phase <= PH_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign in_cas = (phase == PH_COL) || (phase == PH_DATA);

  dram_addr_sel #(.PIN_W(PIN_W)) u_sel (
    .use_col (in_cas),
    .use_ref (phase == PH_REF),
    .row     (row_q),
    .col     (col_q),
    .ref_row (ref_row),
    .pins    (dram_addr)
  );

  assign req_ready   = (phase == PH_IDLE) && !ref_pending;
  assign dram_ras_n  = !((phase == PH_ROW) || in_cas || (phase == PH_REF));
  assign dram_cas_n  = !in_cas;
  assign dram_we_n   = !(in_cas && wr_q);
  assign dram_oe_n   = !(in_cas && !wr_q);
  assign dram_dq_out = wdata_q;
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int PIN_W = 11,
  parameter int T_PRE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [PIN_W-1:0] dram_addr,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n
);
  localparam int HW = $clog2(T_PRE + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  hi_cnt <= HW'(T_PRE);
    else if (!dram_ras_n)                        hi_cnt <= '0;
    else if (hi_cnt < HW'(T_PRE))                hi_cnt <= hi_cnt + 1'b1;
  end

  assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  assert_enables_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> !req_ready);

  assert_precharge_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= HW'(T_PRE)));

  assert_row_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && dram_cas_n && $past(!dram_ras_n)) |-> $stable(dram_addr));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.PIN_W(PIN_W), .T_PRE(T_PRE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .dram_addr  (dram_addr),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n)
);

// File: tb/sim_dram_mux_ctrl.sv
module sim_dram_mux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_ROW      = 2;
  localparam int T_COL      = 2;
  localparam int T_DATA     = 1;
  localparam int T_PRE      = 2;
  localparam int T_REF      = 3;
  localparam int REF_PERIOD = 40;
  localparam int ROWS       = 2048;
  localparam int LAT        = T_ROW + T_COL + T_DATA;

  typedef struct {
    bit          wr;
    logic [21:0] a;
    logic [3:0]  d;
    int          due;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [3:0]  dram_dq_out;
  logic [3:0]  dq_in_r = '0;

  dram_mux_ctrl #(.T_ROW(T_ROW), .T_COL(T_COL), .T_DATA(T_DATA), .T_PRE(T_PRE),
                  .T_REF(T_REF), .REF_PERIOD(REF_PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_in(dq_in_r));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int cyc;
  item_t exp_acc[$];
  item_t exp_rsp[$];
  logic [3:0] shadow [bit [21:0]];
  logic [3:0] mem    [bit [21:0]];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // pin-level memory model and response monitor, sampled on falling edges
  logic        prev_ras = 1'b1, prev_cas = 1'b1;
  logic [10:0] row_l = '0;
  int          ras_low = 0, ras_high = T_PRE, ref_count = 0, last_mark = 0;
  bit          cas_seen = 0, ref_due = 0, this_ref = 0;

  always @(negedge clk) if (rst_n) begin
    if (!dram_ras_n && prev_ras) begin
      check(ras_high >= T_PRE, "R8", "precharge gap", ras_high, T_PRE);
      check(req_ready == 1'b0, "R7", "ready while row strobe low", req_ready, 0);
      row_l    = dram_addr;
      ras_low  = 1;
      ras_high = 0;
      cas_seen = 0;
      this_ref = ref_due;
      ref_due  = 0;
    end else if (!dram_ras_n) ras_low++;
    if (dram_ras_n) ras_high++;

    if (cyc != 0 && cyc % REF_PERIOD == 0 && cyc != last_mark) begin
      ref_due   = 1;
      last_mark = cyc;
    end

    if (!dram_cas_n && prev_cas) begin
      item_t e;
      cas_seen = 1;
      check(ras_low == T_ROW + 1, "R3", "row-to-column delay", ras_low - 1, T_ROW);
      check(!this_ref, "R10", "access started while refresh due", 1, 0);
      if (exp_acc.size() == 0) check(0, "R7", "unexpected access", 1, 0);
      else begin
        e = exp_acc.pop_front();
        check(row_l == e.a[21:11], "R2", "row half", row_l, e.a[21:11]);
        check(dram_addr == e.a[10:0], "R2", "column half", dram_addr, e.a[10:0]);
        check(dram_we_n == !e.wr, "R4", "write enable", dram_we_n, !e.wr);
        check(dram_oe_n == e.wr, "R4", "output enable", dram_oe_n, e.wr);
        if (e.wr) begin
          check(dram_dq_out == e.d, "R4", "write data", dram_dq_out, e.d);
          mem[{row_l, dram_addr}] = dram_dq_out;
        end
      end
    end
    if (!dram_cas_n) check(!dram_ras_n, "R3", "column strobe outside row strobe", dram_ras_n, 0);
    if (!dram_cas_n && !dram_oe_n)
      dq_in_r <= mem.exists({row_l, dram_addr}) ? mem[{row_l, dram_addr}] : 4'h0;

    if (dram_ras_n && !prev_ras) begin
      check(cas_seen == !this_ref, "R9", "refresh is row-only", cas_seen, !this_ref);
      if (this_ref) begin
        check(ras_low == T_REF, "R9", "refresh strobe length", ras_low, T_REF);
        check(row_l == 11'(ref_count % ROWS), "R9", "refresh row", row_l, ref_count % ROWS);
        ref_count++;
      end
    end

    if (rsp_valid) begin
      if (exp_rsp.size() == 0) check(0, "R6", "unexpected done", 1, 0);
      else begin
        item_t r;
        r = exp_rsp.pop_front();
        check(cyc == r.due, "R6", "done cycle", cyc, r.due);
        if (!r.wr) check(rsp_rdata == r.d, "R5", "read data", rsp_rdata, r.d);
      end
    end
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
  end

  task automatic do_req(bit wr, logic [21:0] a, logic [3:0] d);
    item_t e;
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin @(negedge clk); #1; end
    check(!ref_due, "R10", "request taken while refresh due", 1, 0);
    e.wr  = wr;
    e.a   = a;
    e.d   = wr ? d : (shadow.exists(a) ? shadow[a] : 4'h0);
    e.due = cyc + 1 + LAT;
    if (wr) shadow[a] = d;
    exp_acc.push_back(e);
    exp_rsp.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes idle", 0, 1);
    check(rsp_valid == 1'b0, "R1", "done low", rsp_valid, 0);
    check(req_ready == 1'b1, "R1", "ready high", req_ready, 1);
    // corner and pattern writes (R2, R4)
    do_req(1, 22'h000000, 4'h5);
    do_req(1, 22'h3FFFFF, 4'hA);
    do_req(1, 22'h2AAAAA, 4'h3);
    do_req(1, 22'h155555, 4'hC);
    do_req(1, 22'h2AA800, 4'h9);   // same row as 22'h2AAAAA, other column
    do_req(1, 22'h0002AA, 4'h6);   // same column, other row
    // read back (R5), including a never-written address
    do_req(0, 22'h000000, 4'h0);
    do_req(0, 22'h3FFFFF, 4'h0);
    do_req(0, 22'h2AAAAA, 4'h0);
    do_req(0, 22'h2AA800, 4'h0);
    do_req(0, 22'h0002AA, 4'h0);
    do_req(0, 22'h155555, 4'h0);
    do_req(0, 22'h123456, 4'h0);
    // overwrite then read (R5)
    do_req(1, 22'h2AAAAA, 4'hF);
    do_req(0, 22'h2AAAAA, 4'h0);
    // a stream of back-to-back requests crossing refresh deadlines (R7, R10)
    for (int i = 0; i < 40; i++) begin
      logic [21:0] a;
      a = 22'((i * 22'h01F3A7) ^ 22'h0A5A5A);
      do_req(1, a, 4'(i + 3));
      do_req(0, a, 4'h0);
    end
    while (exp_rsp.size() != 0) @(negedge clk);
    // let refreshes run past the row-counter wrap (R9)
    while (ref_count < ROWS + 3) @(negedge clk);
    repeat (T_ROW + T_COL + T_DATA + T_PRE + 2) @(negedge clk);
    check(exp_acc.size() == 0, "R7", "accesses outstanding", exp_acc.size(), 0);
    check(exp_rsp.size() == 0, "R6", "responses outstanding", exp_rsp.size(), 0);
    check(ref_count >= cyc / REF_PERIOD - 1, "R9", "refresh count", ref_count, cyc / REF_PERIOD);
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule